// File: doc/BRIEF.md
# Windowed Watchdog with Early-Refresh Detection

This block is a watchdog that runs on the bus clock and keeps a 7-bit down-counter. Software must rewrite the counter inside a time window. A late rewrite lets the counter fall from 0x40 to 0x3F, and the falling edge of its bit 6 raises a reset request. An early rewrite, made while the counter is still above a programmed window value, also raises a reset request. The counter steps at a rate set by a fixed base divider (4096 bus clocks by default) followed by a prescaler. A 2-bit field selects the prescaler factor from 1, 2, 4 and 8.

Software reaches the block through a single write port with three targets: control, configuration and status. The control word holds a set-only enable bit and a 7-bit counter value. The configuration word holds the prescaler field and a 7-bit window value. A status write clears the sticky cause flag. A reset request is a one-cycle pulse. When the block issues one, it puts itself back into its power-on state, except for the cause flag, which stays set until software clears it or the `rst` input is asserted.

Top module: `wdt_window`

## Requirements
- R1: After `rst`, `count` reads 0x7F, `wd_on`, `rst_req` and `cause_flag` read 0, the window is 0x7F and the prescaler factor is 1.
- R2: While enabled, `count` falls by one every BASE_DIV × 2^psel clock cycles. psel is configuration bits [8:7], with 0..3 giving factors 1, 2, 4 and 8. Every control write restarts the divider chain, so the first decrement comes BASE_DIV × 2^psel cycles after the write edge.
- R3: A control write of value T with bit 6 set, made while enabled or together with enable, raises `rst_req` exactly (T[5:0]+1) × BASE_DIV × 2^psel cycles after the write edge. This is the step in which `count` would go from 0x40 to 0x3F.
- R4: A control write whose value has bit 6 clear raises `rst_req` on the edge after the write when the block is enabled or the same write sets enable (bit 7).
- R5: A control write made while enabled, when the pre-write `count` is greater than the window (configuration bits [6:0]), raises `rst_req`. When `count` is at or below the window, the write loads the new value and no request is raised.
- R6: The enable bit (control bit 7) can only be set. A control write with bit 7 at 0 leaves `wd_on` at 1.
- R7: `rst_req` lasts exactly one cycle. On that edge the block returns to its R1 state (`wd_on` 0, `count` 0x7F, window 0x7F, prescaler factor 1), except for `cause_flag`.
- R8: `cause_flag` is set together with `rst_req` and holds its value. A status write with bit 0 at 1 clears it; a status write with bit 0 at 0 leaves it unchanged.
- R9: While disabled, a control write with bit 7 at 0 loads `count` without raising a request, even if bit 6 is clear, and `count` then stays constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 2 | Write target: 0 control, 1 configuration, 2 status |
| wr_data | input | 9 | Control: [7] enable, [6:0] counter. Configuration: [8:7] psel, [6:0] window. Status: [0] clear flag |
| rst_req | output | 1 | One-cycle reset request |
| cause_flag | output | 1 | Sticky flag recording that this block raised a request |
| wd_on | output | 1 | Enable state |
| count | output | 7 | Current counter value |

## Verification
The bench sweeps every 6-bit load value at the two smallest prescaler factors, and a spread of load values at the two largest. For each case it counts the exact cycle of the timeout. An off-by-one in the underflow compare, or in the divider restart, would move the request one tick early or late. Refreshes are then swept across several window values and refresh delays, and the expected outcome is computed from the count read just before the write edge. A design that compared against the post-write value, or used greater-or-equal, would reset on refreshes that are legal. Further cases cover a load with bit 6 clear (which must reset at once when armed and never when disarmed), an enable bit that a write of 0 must not clear, and a prescaler setting that must not survive a self-issued reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_STAT = 2'd2
  } wdt_sel_e;

endpackage

// File: rtl/wdt_divider.sv
module wdt_divider #(
  parameter int BASE_DIV = 4096,
  parameter int PSEL_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              clear,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick
);
  localparam int PRE_W = (1 << PSEL_W) - 1;

  logic             base_tick;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_lim;

  generate
    if (BASE_DIV <= 1) begin : g_nobase
      assign base_tick = run;
    end else begin : g_base
      localparam int BW = $clog2(BASE_DIV);
      logic [BW-1:0] base_q;
      always_ff @(posedge clk) begin
        if (rst || clear || !run) begin
          base_q <= '0;
        end else if (base_q == BW'(BASE_DIV - 1)) begin
          base_q <= '0;
        end else begin
          base_q <= base_q + 1'b1;
        end
      end
      assign base_tick = run && (base_q == BW'(BASE_DIV - 1));
    end
  endgenerate

  // Factor is 2**psel; the prescaler wraps at factor-1.
  always_comb begin
    pre_lim = PRE_W'((32'd1 << psel) - 32'd1);
  end

  always_ff @(posedge clk) begin
    if (rst || clear || !run) begin
      pre_q <= '0;
    end else if (base_tick) begin
      if (pre_q >= pre_lim) begin
        pre_q <= '0;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign tick = base_tick && (pre_q >= pre_lim);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '1;
    end else if (load) begin
      cnt <= load_val;
    end else if (dec) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter int CNT_W = 7
) (
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] win,
  input  logic             wr_ctrl,
  input  logic             wr_arm,
  input  logic             wr_msb,
  input  logic             tick,
  output logic             fire
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1 << (CNT_W - 1));

  logic armed;
  logic too_early;
  logic low_load;
  logic expire;

  always_comb begin
    armed     = en || (wr_ctrl && wr_arm);
    too_early = wr_ctrl && en && (cnt > win);
    low_load  = wr_ctrl && armed && !wr_msb;
    expire    = en && tick && !wr_ctrl && (cnt == LAST);
    fire      = too_early || low_load || expire;
  end
endmodule

// File: rtl/wdt_window.sv
module wdt_window
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 7,
  parameter int BASE_DIV = 4096,
  parameter int PSEL_W   = 2,
  parameter int DATA_W   = CNT_W + PSEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rst_req,
  output logic              cause_flag,
  output logic              wd_on,
  output logic [CNT_W-1:0]  count
);
  logic              wr_ctrl, wr_cfg, wr_stat;
  logic [CNT_W-1:0]  win_q;
  logic [PSEL_W-1:0] psel_q;
  logic              tick;
  logic              fire;

  always_comb begin
    wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
    wr_cfg  = wr_en && (wr_sel == SEL_CFG);
    wr_stat = wr_en && (wr_sel == SEL_STAT);
  end

  wdt_divider #(.BASE_DIV(BASE_DIV), .PSEL_W(PSEL_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .run   (wd_on),
    .clear (wr_ctrl || fire),
    .psel  (psel_q),
    .tick  (tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .restart  (fire),
    .load     (wr_ctrl),
    .load_val (wr_data[CNT_W-1:0]),
    .dec      (tick && wd_on),
    .cnt      (count)
  );

  wdt_guard #(.CNT_W(CNT_W)) u_guard (
    .en      (wd_on),
    .cnt     (count),
    .win     (win_q),
    .wr_ctrl (wr_ctrl),
    .wr_arm  (wr_data[CNT_W]),
    .wr_msb  (wr_data[CNT_W-1]),
    .tick    (tick),
    .fire    (fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_on      <= 1'b0;
      win_q      <= '1;
      psel_q     <= '0;
      rst_req    <= 1'b0;
      cause_flag <= 1'b0;
    end else begin
      rst_req <= fire;
      if (fire) begin
        wd_on  <= 1'b0;
        win_q  <= '1;
        psel_q <= '0;
      end else begin
        if (wr_ctrl && wr_data[CNT_W]) wd_on <= 1'b1;
        if (wr_cfg) begin
          win_q  <= wr_data[CNT_W-1:0];
          psel_q <= wr_data[CNT_W+PSEL_W-1:CNT_W];
        end
      end
      if (fire) begin
        cause_flag <= 1'b1;
      end else if (wr_stat && wr_data[0]) begin
        cause_flag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/wdt_window_chk.sv
module wdt_window_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             ctrl_wr,
  input logic             stat_clr,
  input logic             rst_req,
  input logic             cause_flag,
  input logic             wd_on,
  input logic [CNT_W-1:0] count
);
  assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  assert_home_R7: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (!wd_on && count == {CNT_W{1'b1}}));

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> cause_flag);

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (cause_flag && !stat_clr) |=> cause_flag);

  assert_enable_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    wd_on |=> (wd_on || rst_req));

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (wd_on && !ctrl_wr) |=>
      (rst_req || count == $past(count) || count == $past(count) - 1'b1));

  assert_msb_live_R3: assert property (@(posedge clk) disable iff (rst)
    wd_on |-> count[CNT_W-1]);

  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!wd_on && !ctrl_wr) |=> $stable(count));
endmodule

bind wdt_window wdt_window_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ctrl_wr    (wr_en && wr_sel == 2'd0),
  .stat_clr   (wr_en && wr_sel == 2'd2 && wr_data[0]),
  .rst_req    (rst_req),
  .cause_flag (cause_flag),
  .wd_on      (wd_on),
  .count      (count)
);

// File: tb/wdt_window_bench.sv
`timescale 1ns/1ps
module wdt_window_bench;
  localparam int BASE = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [8:0] wr_data = '0;
  logic       rst_req, cause_flag, wd_on;
  logic [6:0] count;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdt_window #(.BASE_DIV(BASE)) u_wdt_window (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rst_req(rst_req), .cause_flag(cause_flag), .wd_on(wd_on), .count(count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [8:0] d, output int seen);
    @(negedge clk);
    seen = int'(count);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Returns the number of edges after the last write edge at which rst_req shows.
  task automatic wait_fire(input int lim, output int got);
    got = -1;
    for (int k = 1; k <= lim; k++) begin
      @(posedge clk); @(negedge clk);
      if (rst_req) begin got = k; break; end
    end
  endtask

  initial begin
    int seen, got, p, n, fire_exp;
    int wins[4];
    int tsel[6];
    wins = '{64, 79, 96, 127};
    tsel = '{0, 1, 2, 17, 40, 63};
    do_reset();
    // R1 reset state
    chk("R1 count", count, 127);
    chk("R1 wd_on", wd_on, 0);
    chk("R1 rst_req", rst_req, 0);
    chk("R1 cause_flag", cause_flag, 0);

    // R2/R3 timeout sweep over prescaler and load value
    for (int ps = 0; ps < 4; ps++) begin
      for (int ti = 0; ti < ((ps < 2) ? 64 : 6); ti++) begin
        int t;
        t = (ps < 2) ? ti : tsel[ti];
        p = BASE << ps;
        n = (t + 1) * p;
        do_reset();
        wr(2'd1, 9'((ps << 7) | 127), seen);
        wr(2'd0, 9'(128 | 64 | t), seen);
        got = -1;
        for (int k = 1; k <= n + 4; k++) begin
          @(posedge clk); @(negedge clk);
          if (k == p - 1) chk("R2 hold", count, 64 + t);
          if (k == p && t > 0) chk("R2 step", count, 64 + t - 1);
          if (rst_req) begin got = k; break; end
        end
        chk("R3 timeout cycle", got, n);
        chk("R7 home count", count, 127);
        chk("R7 home wd_on", wd_on, 0);
        chk("R8 flag set", cause_flag, 1);
        @(posedge clk); @(negedge clk);
        chk("R7 one-cycle pulse", rst_req, 0);
      end
    end

    // R5 window sweep; R6 enable survives a bit7=0 refresh
    for (int wi = 0; wi < 4; wi++) begin
      for (int j = 0; j <= 240; j += 8) begin
        do_reset();
        wr(2'd1, 9'(wins[wi]), seen);
        wr(2'd0, 9'h0FF, seen);
        repeat (j) @(posedge clk);
        wr(2'd0, 9'h07F, seen);
        fire_exp = (seen > wins[wi]) ? 1 : 0;
        chk("R5 early refresh", rst_req, fire_exp);
        if (fire_exp == 0) begin
          chk("R5 reload", count, 127);
          chk("R6 enable kept", wd_on, 1);
        end
      end
    end

    // R4 bit 6 clear on enabling write, and while enabled
    do_reset();
    wr(2'd0, 9'h0A0, seen);
    chk("R4 arm with low value", rst_req, 1);
    chk("R4 flag", cause_flag, 1);
    do_reset();
    wr(2'd0, 9'h0D0, seen);
    wr(2'd0, 9'h030, seen);
    chk("R4 low refresh", rst_req, 1);

    // R9 disabled load
    do_reset();
    wr(2'd0, 9'h005, seen);
    chk("R9 no request", rst_req, 0);
    chk("R9 loaded", count, 5);
    chk("R9 stays off", wd_on, 0);
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk("R9 frozen", count, 5);
    chk("R9 no flag", cause_flag, 0);

    // R8 sticky flag
    do_reset();
    wr(2'd0, 9'h0A0, seen);
    chk("R8 set", cause_flag, 1);
    wr(2'd2, 9'h000, seen);
    chk("R8 write0 keeps", cause_flag, 1);
    repeat (50) @(posedge clk);
    @(negedge clk);
    chk("R8 holds", cause_flag, 1);
    wr(2'd2, 9'h001, seen);
    chk("R8 cleared", cause_flag, 0);

    // R7 prescaler returns to factor 1 after a self-issued reset
    do_reset();
    wr(2'd1, 9'h17F, seen);
    wr(2'd0, 9'h0A0, seen);
    wr(2'd0, 9'h0C1, seen);
    wait_fire(200, got);
    chk("R7 prescaler home", got, 2 * BASE);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule